// File: doc/BRIEF.md
# Binary32 Compare to Condition Flags

This block compares two packed IEEE-754 single-precision operands, called d and m, and reduces the result to a 4-bit condition code (N, Z, C, V) plus an invalid-operation flag. It never unpacks the operands. Ordering comes from an integer comparison of the raw patterns, and that comparison is reversed when both operands are negative. A NaN on either side gives the unordered code.

Two control inputs select the variant. `signal_mode_i` chooses the signalling compare, in which any NaN raises the invalid flag. When it is low, only a signalling NaN raises the flag. `zero_mode_i` replaces operand m with the all-zero pattern (+0) to give the compare-with-zero form.

The caller pulses `valid_i` with the operands and controls. One cycle later the registered result appears, together with a one-cycle `valid_o`. The result then holds until the next strobe.

Top module: `fp32_flag_compare`

## Requirements
- R1: A result is registered on the clock edge that samples `valid_i` high. `valid_o` is high for exactly the cycle after each strobe and is low after a cycle with no strobe.
- R2: While reset is asserted, `valid_o`, `nzcv_o` and `invalid_o` are all 0.
- R3: `nzcv_o` holds N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. The possible codes are: equal 4'b0110, less-than 4'b1000, greater-than 4'b0010, unordered 4'b0011.
- R4: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A NaN on either operand gives the unordered code.
- R5: With `signal_mode_i` low, `invalid_o` is 1 only when an operand is a NaN whose fraction bit 22 is 0 (a signalling NaN). A quiet NaN leaves it 0.
- R6: With `signal_mode_i` high, `invalid_o` is 1 whenever either operand is a NaN. When neither operand is a NaN, `invalid_o` is 0 in both modes.
- R7: The operands are equal when their bit patterns match or when both have zero magnitude, so +0 equals -0.
- R8: When the signs differ and the operands are not equal, the operand with bit 31 set is the smaller one.
- R9: When the signs match, the operands are ordered by unsigned comparison of their 32-bit patterns. The sense of that comparison is inverted when both are negative. This covers denormals and infinities.
- R10: With `zero_mode_i` high, operand m is taken as +0 and the value on `op_m_i` has no effect on the result.
- R11: While `valid_i` is low, `nzcv_o` and `invalid_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe: sample operands and controls this cycle |
| signal_mode_i | input | 1 | 1 = any NaN is invalid; 0 = only a signalling NaN is invalid |
| zero_mode_i | input | 1 | 1 = compare d against +0 instead of m |
| op_d_i | input | 32 | First operand d, packed binary32 |
| op_m_i | input | 32 | Second operand m, packed binary32 |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| nzcv_o | output | 4 | Condition code {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Every result and `valid_o` are due exactly one clock edge after the edge that sees `valid_i` high. The bench drives each strobe on a falling edge and drops it on the next falling edge. It reads the outputs at that second falling edge, half a period after the register has loaded. The hold checks wait several idle cycles, with the inputs changing, before they read the outputs again. The checker states the one-cycle relation directly with `|=>` from the strobe.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Per-operand classification bits
  typedef struct packed {
    logic nan;   // exponent all ones, fraction nonzero
    logic snan;  // NaN with top fraction bit clear
    logic zmag;  // magnitude is zero
  } opclass_t;

  localparam logic [3:0] FLAGS_UNORD = 4'b0011;
  localparam logic [3:0] FLAGS_EQ    = 4'b0110;
  localparam logic [3:0] FLAGS_LT    = 4'b1000;
  localparam logic [3:0] FLAGS_GT    = 4'b0010;

  // Map relation outcome to {N,Z,C,V}; unordered dominates
  function automatic logic [3:0] encode_flags(input logic unord,
                                              input logic eq,
                                              input logic lt);
    if (unord)   return FLAGS_UNORD;
    else if (eq) return FLAGS_EQ;
    else if (lt) return FLAGS_LT;
    else         return FLAGS_GT;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output fpcmp_pkg::opclass_t   cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op_i[FRAC_W-1:0];

  always_comb begin
    cls_o.nan  = (&exp_f) && (|frac_f);
    cls_o.snan = cls_o.nan && !frac_f[FRAC_W-1];
    cls_o.zmag = (exp_f == '0) && (frac_f == '0);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              both_zero_i,
  output logic              eq_o,
  output logic              lt_o
);
  localparam int SGN = WORD_W - 1;

  logic same_bits;
  logic a_below_b;

  assign same_bits = (a_i == b_i);
  assign a_below_b = (a_i < b_i);

  always_comb begin
    eq_o = same_bits || both_zero_i;
    if (eq_o)
      lt_o = 1'b0;
    else if (a_i[SGN] != b_i[SGN])
      lt_o = a_i[SGN];            // negative side is smaller
    else
      lt_o = a_i[SGN] ^ a_below_b; // magnitude order flips for negatives
  end
endmodule

// File: rtl/fp32_flag_compare.sv
module fp32_flag_compare #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic                   signal_mode_i,
  input  logic                   zero_mode_i,
  input  logic [EXP_W+FRAC_W:0]  op_d_i,
  input  logic [EXP_W+FRAC_W:0]  op_m_i,
  output logic                   valid_o,
  output logic [3:0]             nzcv_o,
  output logic                   invalid_o
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPS  = 2;

  logic [WORD_W-1:0]   opnd [N_OPS];
  fpcmp_pkg::opclass_t cls  [N_OPS];

  assign opnd[0] = op_d_i;
  assign opnd[1] = zero_mode_i ? '0 : op_m_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (opnd[g]),
      .cls_o (cls[g])
    );
  end

  // Named internal events for the checker
  logic       unord_w;
  logic       inv_w;
  logic       eq_w;
  logic       lt_w;
  logic [3:0] flags_nxt;

  assign unord_w = cls[0].nan | cls[1].nan;
  assign inv_w   = (cls[0].nan && (signal_mode_i || cls[0].snan)) ||
                   (cls[1].nan && (signal_mode_i || cls[1].snan));

  fpcmp_order #(.WORD_W(WORD_W)) u_ord (
    .a_i         (opnd[0]),
    .b_i         (opnd[1]),
    .both_zero_i (cls[0].zmag & cls[1].zmag),
    .eq_o        (eq_w),
    .lt_o        (lt_w)
  );

  assign flags_nxt = fpcmp_pkg::encode_flags(unord_w, eq_w, lt_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      nzcv_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        nzcv_o    <= flags_nxt;
        invalid_o <= inv_w;
      end
    end
  end
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  valid_i,
  input logic                  signal_mode_i,
  input logic                  zero_mode_i,
  input logic [EXP_W+FRAC_W:0] op_d_i,
  input logic                  valid_o,
  input logic [3:0]            nzcv_o,
  input logic                  invalid_o,
  input logic                  eq_w,
  input logic                  lt_w
);
  logic d_nan;
  logic d_zero;
  assign d_nan  = (&op_d_i[EXP_W+FRAC_W-1:FRAC_W]) && (|op_d_i[FRAC_W-1:0]);
  assign d_zero = (op_d_i[EXP_W+FRAC_W-1:0] == '0);

  // R1
  strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  // R1
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);
  // R2
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && nzcv_o == 4'b0000 && !invalid_o));
  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (nzcv_o == 4'b0110 || nzcv_o == 4'b1000 ||
                 nzcv_o == 4'b0010 || nzcv_o == 4'b0011));
  // R4
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && d_nan) |=> (nzcv_o == 4'b0011));
  // R5
  invalid_needs_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && invalid_o) |-> (nzcv_o == 4'b0011));
  // R6
  signal_nan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && signal_mode_i && d_nan) |=> invalid_o);
  // R7
  zero_pair_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && zero_mode_i && d_zero) |=> (nzcv_o == 4'b0110 && !invalid_o));
  // R8
  eq_lt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eq_w && lt_w));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(nzcv_o) && $stable(invalid_o)));
endmodule

bind fp32_flag_compare fpcmp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .valid_i       (valid_i),
  .signal_mode_i (signal_mode_i),
  .zero_mode_i   (zero_mode_i),
  .op_d_i        (op_d_i),
  .valid_o       (valid_o),
  .nzcv_o        (nzcv_o),
  .invalid_o     (invalid_o),
  .eq_w          (eq_w),
  .lt_w          (lt_w)
);

// File: tb/sim_fp32_flag_compare.sv
module sim_fp32_flag_compare;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        signal_mode_i = 1'b0;
  logic        zero_mode_i = 1'b0;
  logic [31:0] op_d_i = '0;
  logic [31:0] op_m_i = '0;
  logic        valid_o;
  logic [3:0]  nzcv_o;
  logic        invalid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_flag_compare u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .signal_mode_i(signal_mode_i), .zero_mode_i(zero_mode_i),
    .op_d_i(op_d_i), .op_m_i(op_m_i),
    .valid_o(valid_o), .nzcv_o(nzcv_o), .invalid_o(invalid_o)
  );

  localparam logic [31:0] P_ZERO = 32'h0000_0000, N_ZERO = 32'h8000_0000;
  localparam logic [31:0] P_INF  = 32'h7F80_0000, N_INF  = 32'hFF80_0000;
  localparam logic [31:0] QNAN   = 32'h7FC0_0000, SNAN   = 32'h7F80_0001;
  localparam logic [31:0] ONE    = 32'h3F80_0000, TWO    = 32'h4000_0000;
  localparam logic [31:0] M_ONE  = 32'hBF80_0000, M_TWO  = 32'hC000_0000;
  localparam logic [31:0] DEN    = 32'h0000_0001, M_DEN  = 32'h8000_0001;

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return P_ZERO;  1: return N_ZERO;  2: return P_INF;   3: return N_INF;
      4: return QNAN;    5: return SNAN;    6: return ONE;     7: return TWO;
      8: return M_ONE;   9: return M_TWO;   10: return DEN;    11: return M_DEN;
      12: return 32'hFFC0_0001;             default: return 32'h007F_FFFF;
    endcase
  endfunction

  // Reference: map each value to a monotonic unsigned key, -0 folded onto +0
  function automatic logic [32:0] sort_key(input logic [31:0] x);
    logic [31:0] v;
    v = (x[30:0] == 0) ? 32'h0 : x;
    return v[31] ? {1'b0, ~v} : {1'b1, v};
  endfunction

  function automatic logic [4:0] ref_result(input logic [31:0] d, input logic [31:0] m,
                                            input logic sig, input logic zm);
    logic [31:0] mm;
    logic dn, mn, ds, ms, inv;
    mm = zm ? 32'h0 : m;
    dn = (d[30:23] == 8'hFF) && (d[22:0] != 0);
    mn = (mm[30:23] == 8'hFF) && (mm[22:0] != 0);
    ds = dn && !d[22];
    ms = mn && !mm[22];
    inv = sig ? (dn || mn) : (ds || ms);
    if (dn || mn)                          return {inv, 4'b0011};
    else if (sort_key(d) == sort_key(mm))  return {inv, 4'b0110};
    else if (sort_key(d) <  sort_key(mm))  return {inv, 4'b1000};
    else                                   return {inv, 4'b0010};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Strobe one compare, read it half a period after the capturing edge
  task automatic run_cmp(input string req, input logic [31:0] d, input logic [31:0] m,
                         input logic sig, input logic zm);
    @(negedge clk);
    op_d_i = d; op_m_i = m; signal_mode_i = sig; zero_mode_i = zm; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " valid"}, {4'b0, valid_o}, 5'b00001);
    check(req, {invalid_o, nzcv_o}, ref_result(d, m, sig, zm));
  endtask

  task automatic t_reset;
    // R2
    check("R2 reset", {invalid_o, nzcv_o}, 5'b0);
    check("R2 reset valid", {4'b0, valid_o}, 5'b0);
  endtask

  task automatic t_basic;
    run_cmp("R3 equal", ONE, ONE, 0, 0);
    check("R3 eq code", {invalid_o, nzcv_o}, 5'b00110);
    run_cmp("R3 less", ONE, TWO, 0, 0);
    check("R3 lt code", {invalid_o, nzcv_o}, 5'b01000);
    run_cmp("R3 greater", TWO, ONE, 0, 0);
    check("R3 gt code", {invalid_o, nzcv_o}, 5'b00010);
  endtask

  task automatic t_signs;
    run_cmp("R7 +0 vs -0", P_ZERO, N_ZERO, 0, 0);
    check("R7 zero eq", {invalid_o, nzcv_o}, 5'b00110);
    run_cmp("R8 neg vs pos", M_ONE, ONE, 0, 0);
    check("R8 lt", {invalid_o, nzcv_o}, 5'b01000);
    run_cmp("R8 pos vs neg den", DEN, M_DEN, 0, 0);
    check("R8 gt", {invalid_o, nzcv_o}, 5'b00010);
    run_cmp("R9 both neg", M_TWO, M_ONE, 0, 0);
    check("R9 neg order", {invalid_o, nzcv_o}, 5'b01000);
    run_cmp("R9 den vs zero", DEN, P_ZERO, 0, 0);
    check("R9 den gt", {invalid_o, nzcv_o}, 5'b00010);
    run_cmp("R9 -inf vs -2", N_INF, M_TWO, 0, 0);
    check("R9 -inf lt", {invalid_o, nzcv_o}, 5'b01000);
  endtask

  task automatic t_nan;
    run_cmp("R4 qnan quiet", QNAN, ONE, 0, 0);
    check("R5 qnan no inv", {invalid_o, nzcv_o}, 5'b00011);
    run_cmp("R5 snan quiet", ONE, SNAN, 0, 0);
    check("R5 snan inv", {invalid_o, nzcv_o}, 5'b10011);
    run_cmp("R6 qnan signalling", ONE, QNAN, 1, 0);
    check("R6 qnan inv", {invalid_o, nzcv_o}, 5'b10011);
    run_cmp("R6 numbers signalling", M_ONE, P_INF, 1, 0);
    check("R6 no nan no inv", {invalid_o, nzcv_o}, 5'b01000);
  endtask

  task automatic t_zero_mode;
    run_cmp("R10 m NaN ignored", ONE, SNAN, 1, 1);
    check("R10 vs zero", {invalid_o, nzcv_o}, 5'b00010);
    run_cmp("R10 -0 vs zero", N_ZERO, M_ONE, 0, 1);
    check("R10 zero eq", {invalid_o, nzcv_o}, 5'b00110);
    run_cmp("R10 neg den vs zero", M_DEN, TWO, 0, 1);
    check("R10 lt", {invalid_o, nzcv_o}, 5'b01000);
  endtask

  task automatic t_hold;
    run_cmp("R11 setup", SNAN, ONE, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_d_i = ONE; op_m_i = TWO; signal_mode_i = 0; zero_mode_i = 0;
    end
    check("R11 hold", {invalid_o, nzcv_o}, 5'b10011);
    check("R1 valid pulse", {4'b0, valid_o}, 5'b0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    op_d_i = TWO; op_m_i = ONE; signal_mode_i = 0; zero_mode_i = 0; valid_i = 1;
    @(negedge clk);
    check("R1 first", {valid_o, nzcv_o}, 5'b10010);
    op_d_i = ONE; op_m_i = TWO;
    @(negedge clk);
    valid_i = 0;
    check("R1 second", {valid_o, nzcv_o}, 5'b11000);
    @(negedge clk);
    check("R1 drop", {4'b0, valid_o}, 5'b0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 14; j++)
        for (int s = 0; s < 2; s++)
          run_cmp("R9 sweep", pat(i), pat(j), s[0], 1'b0);
  endtask

  task automatic t_random;
    logic [31:0] lfsr = 32'hACE1_2345;
    logic [31:0] a;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_cmp("R8 random", a, (k % 5 == 0) ? {~a[31], a[30:0]} : lfsr, k[0], (k % 7 == 0));
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_signs();
    t_nan();
    t_zero_mode();
    t_hold();
    t_back_to_back();
    t_sweep();
    t_random();
    finish_run();
  end
endmodule